// File: doc/BRIEF.md
# Watchdog Timer with Selectable Prescaler Tap

The block is a watchdog counter that runs from the oscillator clock. A free-running binary prescaler counts every enabled cycle, and one of its stages is picked as the clock for an upper counter. Each time the picked stage completes a full cycle, the upper counter advances by one. When the upper counter wraps past its maximum value, the watchdog has expired. It then sets a sticky flag and sends a one-cycle request to the interrupt controller or to the reset logic.

Software uses the watchdog through one byte-wide control register on a simple synchronous register bus. The register sets the run state, the tap code and the action taken on expiry. Writing the clear bit restarts the whole count, and this is how software services the watchdog. A static strap input lengthens every tap by one binary stage. With the strap high, tap code c divides the oscillator by 2^(BASE_EXP + 2c). With the strap low, the divisor is twice that. The upper counter has CNT_W bits, so the time to expire is 2^(CNT_W + BASE_EXP + 2c) oscillator cycles, doubled when the strap is low. With the default parameters (BASE_EXP = 8, CNT_W = 8) this is 2^(16 + 2c) cycles.

Top module: `wdog_timer`

## Requirements
- R1: After reset the control register reads 0x01 and both request outputs are low.
- R2: Control byte layout: bit 7 is the run enable, bit 5 is the action select, and bits 2:0 are the tap code. These bits are read/write. Bit 4 is the overflow flag and is read-only. Bits 6 and 3 always read 0. Writing bits 4 and 3 has no effect.
- R3: With the strap high and the action select at 0, a write of the run enable together with the clear bit at cycle W gives an interrupt pulse at cycle W + 2^(CNT_W + BASE_EXP + 2·code).
- R4: With the strap low, the same time to expire is doubled.
- R5: A write of tap code 5, 6 or 7 leaves the previous tap code in place. The register reads back the previous code, and the time to expire follows that code.
- R6: Writing 1 to bit 6 zeroes the prescaler and the upper counter and clears the overflow flag. Bit 6 reads back as 0.
- R7: While the run enable is 0, the prescaler and the upper counter hold their values and no request is raised. After the run enable returns to 1 (without clear), the count continues from the held value.
- R8: On expiry the overflow flag is set. A one-cycle pulse appears on the interrupt output when the action select is 0, or on the reset-request output when it is 1. The flag stays set until a clear or a reset.
- R9: If a clear write lands in the same cycle as an expiry, the clear wins. No pulse is sent, the flag stays 0, and a fresh period starts.
- R10: A read at any address other than CTRL_ADDR returns 0. A write at such an address changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rstN | input | 1 | Active-low synchronous reset |
| regAddr | input | ADDR_W | Register bus address |
| regWe | input | 1 | Register bus write enable |
| regWdata | input | 8 | Register bus write data |
| regRdata | output | 8 | Register bus read data (combinational) |
| prescStrap | input | 1 | Static strap: 1 selects the short taps, 0 adds one halving stage |
| irqReq | output | 1 | One-cycle overflow interrupt request |
| rstReq | output | 1 | One-cycle overflow reset request |

## Verification
The counter clear and the overflow can fall in the same cycle. This happens when software services the watchdog at the last possible moment. The bench provokes the collision by timing a clear write so that it takes effect exactly on the edge where the upper counter would wrap. The result is judged at the outputs: no pulse may appear in that cycle, the flag must read 0 in the following cycle, and the next pulse must come one full period after the clear.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

  // number of legal tap codes (0..4); codes at or above this are refused
  localparam int unsigned NUM_TAPS = 5;

  // control byte field positions
  localparam int unsigned BIT_RUN   = 7;
  localparam int unsigned BIT_CLEAR = 6;
  localparam int unsigned BIT_ACT   = 5;
  localparam int unsigned BIT_FLAG  = 4;

  localparam logic [7:0] CTRL_RESET = 8'h01;
  // bits stored straight from a write: run, action, tap code
  localparam logic [7:0] RW_MASK    = 8'hA7;

  // strobes from control to datapath
  typedef struct packed {
    logic       run;
    logic       clear;
    logic [2:0] tapCode;
  } dpCtl_t;

endpackage

// File: rtl/wdog_datapath.sv
module wdog_datapath
  import wdog_pkg::*;
#(
  parameter int BASE_EXP = 8,
  parameter int CNT_W    = 8
) (
  input  logic   clk,
  input  logic   rstN,
  input  dpCtl_t ctl,
  input  logic   prescStrap,
  output logic   wrap
);

  localparam int PRE_W = BASE_EXP + 2 * (NUM_TAPS - 1) + 1;

  logic [PRE_W-1:0] presc;
  logic [CNT_W-1:0] upper;
  logic [NUM_TAPS-1:0] carryShort;
  logic [NUM_TAPS-1:0] carryLong;
  logic tick;

  // carry out of the low K (short) or K+1 (long) prescaler stages
  for (genvar g = 0; g < NUM_TAPS; g++) begin : g_tap
    localparam int K = BASE_EXP + 2 * g;
    assign carryShort[g] = &presc[K-1:0];
    assign carryLong[g]  = &presc[K:0];
  end

  always_comb begin
    tick = 1'b0;
    if (ctl.run && (ctl.tapCode < 3'(NUM_TAPS))) begin
      tick = prescStrap ? carryShort[ctl.tapCode] : carryLong[ctl.tapCode];
    end
  end

  assign wrap = tick && (&upper) && !ctl.clear;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      presc <= '0;
      upper <= '0;
    end else if (ctl.clear) begin
      presc <= '0;
      upper <= '0;
    end else if (ctl.run) begin
      presc <= presc + 1'b1;
      if (tick) upper <= upper + 1'b1;
    end
  end

endmodule

// File: rtl/wdog_ctrl.sv
module wdog_ctrl
  import wdog_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrCtl,
  input  logic [7:0] wrData,
  input  logic       wrap,
  output dpCtl_t     ctl,
  output logic [7:0] rdByte,
  output logic       ovfFlag,
  output logic       irqReq,
  output logic       rstReq
);

  logic [7:0] ctrlQ;
  logic [7:0] ctrlD;
  logic       clearStb;

  assign clearStb = wrCtl && wrData[BIT_CLEAR];

  always_comb begin
    ctrlD = ctrlQ;
    if (wrCtl) begin
      ctrlD = (wrData & RW_MASK) | (ctrlQ & ~RW_MASK);
      if (wrData[2:0] >= 3'(NUM_TAPS)) ctrlD[2:0] = ctrlQ[2:0];
    end
    if (clearStb)  ctrlD[BIT_FLAG] = 1'b0;
    else if (wrap) ctrlD[BIT_FLAG] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlQ  <= CTRL_RESET;
      irqReq <= 1'b0;
      rstReq <= 1'b0;
    end else begin
      ctrlQ  <= ctrlD;
      irqReq <= wrap && !ctrlQ[BIT_ACT];
      rstReq <= wrap && ctrlQ[BIT_ACT];
    end
  end

  assign ctl.run     = ctrlQ[BIT_RUN];
  assign ctl.clear   = clearStb;
  assign ctl.tapCode = ctrlQ[2:0];
  assign rdByte      = ctrlQ;
  assign ovfFlag     = ctrlQ[BIT_FLAG];

endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
  import wdog_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int CTRL_ADDR = 0,
  parameter int BASE_EXP  = 8,
  parameter int CNT_W     = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWe,
  input  logic [7:0]        regWdata,
  output logic [7:0]        regRdata,
  input  logic              prescStrap,
  output logic              irqReq,
  output logic              rstReq
);

  localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_ADDR);

  dpCtl_t     dpCtl;
  logic       addrHit;
  logic       wrap;
  logic       ovfFlag;
  logic [7:0] rdByte;
  logic       ctlRun;
  logic       ctlClear;
  logic [2:0] ctlTap;

  assign addrHit  = (regAddr == CTRL_A);
  assign regRdata = addrHit ? rdByte : 8'h00;
  assign ctlRun   = dpCtl.run;
  assign ctlClear = dpCtl.clear;
  assign ctlTap   = dpCtl.tapCode;

  wdog_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .wrCtl   (regWe && addrHit),
    .wrData  (regWdata),
    .wrap    (wrap),
    .ctl     (dpCtl),
    .rdByte  (rdByte),
    .ovfFlag (ovfFlag),
    .irqReq  (irqReq),
    .rstReq  (rstReq)
  );

  wdog_datapath #(
    .BASE_EXP (BASE_EXP),
    .CNT_W    (CNT_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .ctl        (dpCtl),
    .prescStrap (prescStrap),
    .wrap       (wrap)
  );

endmodule

// File: rtl/wdog_checker.sv
module wdog_checker
  import wdog_pkg::*;
(
  input logic       clk,
  input logic       rstN,
  input logic       irqReq,
  input logic       rstReq,
  input logic       ovfFlag,
  input logic       runEn,
  input logic       clrStb,
  input logic [2:0] tapCode
);

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    (irqReq || rstReq) |=> !(irqReq || rstReq)); // R8

  AST_PULSE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    !(irqReq && rstReq)); // R8

  AST_PULSE_HAS_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    (irqReq || rstReq) |-> ovfFlag); // R8

  AST_FLAG_RISE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ovfFlag) |-> (irqReq || rstReq)); // R8

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (ovfFlag && !clrStb) |=> ovfFlag); // R8

  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rstN)
    clrStb |=> (!ovfFlag && !irqReq && !rstReq)); // R9

  AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    !runEn |=> (!irqReq && !rstReq)); // R7

  AST_TAP_LEGAL: assert property (@(posedge clk) disable iff (!rstN)
    tapCode < 3'(NUM_TAPS)); // R5

endmodule

bind wdog_timer wdog_checker u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .irqReq  (irqReq),
  .rstReq  (rstReq),
  .ovfFlag (ovfFlag),
  .runEn   (ctlRun),
  .clrStb  (ctlClear),
  .tapCode (ctlTap)
);

// File: tb/wdog_timer_tb_top.sv
`timescale 1ns/1ps
module wdog_timer_tb_top;

  localparam int BASE = 2;
  localparam int CW   = 4;
  localparam int AW   = 4;
  localparam int P0   = 1 << (CW + BASE);   // time to expire, code 0, strap high
  localparam logic [AW-1:0] CTRL_A  = '0;
  localparam logic [AW-1:0] OTHER_A = 4'd3;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [AW-1:0] regAddr = '0;
  logic          regWe = 1'b0;
  logic [7:0]    regWdata = '0;
  logic [7:0]    regRdata;
  logic          prescStrap = 1'b1;
  logic          irqReq;
  logic          rstReq;

  int cyc = 0;
  int nChecks = 0;
  int nFails = 0;
  int pulseCount = 0;
  bit finished = 1'b0;

  typedef struct {
    int    at;
    bit    isRst;
    string req;
  } expItem_t;
  expItem_t expQ[$];
  expItem_t monItem;

  wdog_timer #(
    .ADDR_W    (AW),
    .CTRL_ADDR (0),
    .BASE_EXP  (BASE),
    .CNT_W     (CW)
  ) dut_i (
    .clk        (clk),
    .rstN       (rstN),
    .regAddr    (regAddr),
    .regWe      (regWe),
    .regWdata   (regWdata),
    .regRdata   (regRdata),
    .prescStrap (prescStrap),
    .irqReq     (irqReq),
    .rstReq     (rstReq)
  );

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // driver side of the scoreboard
  task automatic expectPulse(input int at, input bit isRst, input string req);
    expItem_t it;
    it.at = at; it.isRst = isRst; it.req = req;
    expQ.push_back(it);
  endtask

  // monitor: pops expected pulses and compares cycle and kind
  always @(negedge clk) begin
    if (rstN) begin
      if (irqReq || rstReq) begin
        pulseCount++;
        if (expQ.size() == 0) begin
          nChecks++; nFails++;
          $display("FAIL R8: actual unexpected pulse at cycle %0d expected none", cyc);
        end else begin
          monItem = expQ.pop_front();
          nChecks++;
          if (monItem.at != cyc || monItem.isRst != rstReq) begin
            nFails++;
            $display("FAIL %s: actual pulse cycle %0d kind %0d expected cycle %0d kind %0d",
                     monItem.req, cyc, rstReq, monItem.at, monItem.isRst);
          end
        end
      end else if (expQ.size() > 0 && expQ[0].at < cyc) begin
        monItem = expQ.pop_front();
        nChecks++; nFails++;
        $display("FAIL %s: actual no pulse expected pulse at cycle %0d", monItem.req, monItem.at);
      end
    end
  end

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d, output int at);
    @(negedge clk);
    regAddr = a; regWe = 1'b1; regWdata = d;
    @(posedge clk);
    #1 at = cyc;
    @(negedge clk);
    regWe = 1'b0; regAddr = CTRL_A;
  endtask

  task automatic wrAt(input int target, input logic [7:0] d);
    @(negedge clk);
    while (cyc < target - 1) @(negedge clk);
    regAddr = CTRL_A; regWe = 1'b1; regWdata = d;
    @(posedge clk);
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [7:0] v);
    @(negedge clk);
    regAddr = a;
    #1 v = regRdata;
    regAddr = CTRL_A;
  endtask

  task automatic waitUntil(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin : watchdog
    #(200000 * 5);
    nChecks++; nFails++;
    $display("FAIL R1: actual watchdog expired expected test end");
    finish();
  end

  initial begin : stim
    logic [7:0] v;
    int w, w3, pc;
    repeat (4) @(posedge clk);
    @(negedge clk) rstN = 1'b1;

    // R1 reset state
    rd(CTRL_A, v); check("R1", v, 8'h01);
    check("R1", {irqReq, rstReq}, 0);

    // R10 other address
    rd(OTHER_A, v); check("R10", v, 0);
    wr(OTHER_A, 8'hFF, w);
    rd(CTRL_A, v); check("R10", v, 8'h01);

    // R2 layout and read-only bits
    wr(CTRL_A, 8'h3C, w);
    rd(CTRL_A, v); check("R2", v, 8'h24);
    // R6 clear bit reads 0
    wr(CTRL_A, 8'h64, w);
    rd(CTRL_A, v); check("R6", v, 8'h24);

    // R3 code 0, interrupt
    wr(CTRL_A, 8'hC0, w);
    expectPulse(w + P0, 1'b0, "R3");
    waitUntil(w + P0 + 6);
    rd(CTRL_A, v); check("R8", v, 8'h90);
    wr(CTRL_A, 8'h00, w);
    rd(CTRL_A, v); check("R8", v, 8'h10);

    // R6 clear drops flag
    wr(CTRL_A, 8'h40, w);
    rd(CTRL_A, v); check("R6", v, 8'h00);

    // R3 code 1, reset request
    wr(CTRL_A, 8'hE1, w);
    expectPulse(w + P0 * 4, 1'b1, "R3");
    waitUntil(w + P0 * 4 + 4);
    rd(CTRL_A, v); check("R8", v, 8'hB1);
    wr(CTRL_A, 8'h41, w);
    rd(CTRL_A, v); check("R6", v, 8'h01);

    // R4 strap low doubles
    prescStrap = 1'b0;
    wr(CTRL_A, 8'hC0, w);
    expectPulse(w + P0 * 2, 1'b0, "R4");
    waitUntil(w + P0 * 2 + 6);
    wr(CTRL_A, 8'h40, w);
    prescStrap = 1'b1;

    // R5 prohibited codes
    wr(CTRL_A, 8'h42, w);
    rd(CTRL_A, v); check("R5", v, 8'h02);
    wr(CTRL_A, 8'h47, w);
    rd(CTRL_A, v); check("R5", v, 8'h02);
    wr(CTRL_A, 8'hC5, w);
    rd(CTRL_A, v); check("R5", v, 8'h82);
    expectPulse(w + P0 * 16, 1'b0, "R5");
    waitUntil(w + P0 * 16 + 6);
    wr(CTRL_A, 8'h40, w);

    // R7 hold while disabled, then resume
    wr(CTRL_A, 8'hC0, w);
    wrAt(w + 40, 8'h00);
    pc = pulseCount;
    waitUntil(w + 200);
    check("R7", pulseCount, pc);
    wr(CTRL_A, 8'h80, w3);
    expectPulse(w3 + P0 - 40, 1'b0, "R7");
    waitUntil(w3 + P0);
    wr(CTRL_A, 8'h40, w);

    // R9 clear on the expiry edge
    wr(CTRL_A, 8'hC0, w);
    wrAt(w + P0, 8'hC0);
    rd(CTRL_A, v); check("R9", v, 8'h80);
    expectPulse(w + 2 * P0, 1'b0, "R9");
    waitUntil(w + 2 * P0 + 6);
    wr(CTRL_A, 8'h40, w);

    repeat (10) @(negedge clk);
    while (expQ.size() > 0) begin
      monItem = expQ.pop_front();
      nChecks++; nFails++;
      $display("FAIL %s: actual no pulse expected pulse at cycle %0d", monItem.req, monItem.at);
    end
    finish();
  end

endmodule